// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Registers

This block keeps one sticky interrupt-request flag per DMA channel for ten channels. Each channel delivers a single-cycle request pulse, and that pulse latches the channel's flag. Software reads the flags through two byte-wide registers on a plain register bus. The first register covers channels 0 to 4 and the second covers channels 5 to 9. Software acknowledges a channel by writing a 0 to its bit. A 1 written to a bit leaves that bit as it was, so a handler writes all ones except at the bits it wants to drop.

The block has no path from any downstream interrupt controller. Acknowledging a request there therefore never changes a flag held here. The flags are also brought out as a vector, along with one registered summary line that is high while any flag is set.

The bus is a simple strobe interface and not a stream. In any cycle with `bus_en_i` high, the access completes in that same cycle. There is no back-pressure, and read data is valid combinationally in the cycle of the access.

Top module: `dmairq_status`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, every flag is 0, `pending_o` is 0 and `bus_rdata_o` is 0.
- R2: A high bit `ch_req_i[n]` at a rising clock edge sets flag n at that edge. The flag then stays at 1 until software clears it.
- R3: Register layout. The register at address 0x0 has channel k in bit k, for k = 0..4. The register at address 0x8 has channel 5+k in bit k. Bits 7..5 of both registers always read 0.
- R4: A write (`bus_en_i`=1, `bus_we_i`=1) to a register with data bit k = 0 clears the matching flag at that clock edge.
- R5: A write with data bit k = 1 leaves the matching flag unchanged.
- R6: No bus write can set a flag. Only `ch_req_i` sets flags.
- R7: If a request and a clearing write hit the same flag at the same edge, the flag ends at 1.
- R8: A write to any address other than 0x0 and 0x8 changes no flag. A read of any other address, or any cycle with `bus_en_i`=0, returns 0.
- R9: `pending_o` equals the OR of all ten flags as they were one clock cycle earlier.
- R10: `bus_rdata_o` returns the register contents from before this cycle's edge. A write cycle reads back the value it is about to modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_req_i | input | 10 | Per-channel request pulses; bit n is channel n |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte address of the access |
| bus_wdata_i | input | 8 | Write data; 0 clears, 1 keeps |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| flag_o | output | 10 | Current flag per channel |
| pending_o | output | 1 | Registered OR of all flags |

## Verification
The bench aims at the cycle where a request and a clearing write land on the same bit. A design that gives the write priority would silently lose that request. It writes all-ones and random patterns to look for designs that treat a written 1 as a set or as a toggle. It also writes to the register of the other group to catch crossed group decoding. Addresses between and beyond the two registers are written and read to expose partial address decoding, which would either corrupt flags or alias data onto the bus. `pending_o` is compared one cycle late throughout, which catches a combinational or two-stage summary.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int DEF_NUM_CH     = 10;
  localparam int DEF_GRP_CH     = 5;
  localparam int DEF_REG_W      = 8;
  localparam int DEF_ADDR_W     = 4;
  localparam int DEF_GRP_STRIDE = 8;

  function automatic int grp_count(input int nch, input int per);
    return (nch + per - 1) / per;
  endfunction
endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode #(
  parameter int NUM_GRP    = 2,
  parameter int ADDR_W     = 4,
  parameter int GRP_STRIDE = 8
) (
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [NUM_GRP-1:0] grp_hit_o,
  output logic [NUM_GRP-1:0] grp_wr_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] GRP_ADDR = ADDR_W'(g * GRP_STRIDE);
    assign grp_hit_o[g] = bus_en_i && (bus_addr_i == GRP_ADDR);
    assign grp_wr_o[g]  = grp_hit_o[g] && bus_we_i;
  end
endmodule

// File: rtl/dmairq_bank.sv
module dmairq_bank #(
  parameter int GRP_CH  = 5,
  parameter int BASE_CH = 0,
  parameter int NUM_CH  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_CH-1:0] req_i,
  input  logic              wr_i,
  input  logic [GRP_CH-1:0] wdata_i,
  output logic [GRP_CH-1:0] flag_o
);
  for (genvar b = 0; b < GRP_CH; b++) begin : g_bit
    localparam int CH = BASE_CH + b;
    if (CH < NUM_CH) begin : g_live
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    flag_q <= 1'b0;
        else if (req_i[b])             flag_q <= 1'b1;
        else if (wr_i && !wdata_i[b])  flag_q <= 1'b0;
      end
      assign flag_o[b] = flag_q;

      assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[b] |=> flag_o[b]);
      assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wdata_i[b] && !req_i[b]) |=> !flag_o[b]);
      assert_keep_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[b] && !req_i[b]) |=> $stable(flag_o[b]));
      assert_no_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i[b] |=> !$rose(flag_o[b]));
    end else begin : g_pad
      assign flag_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/dmairq_readmux.sv
module dmairq_readmux #(
  parameter int NUM_GRP = 2,
  parameter int GRP_CH  = 5,
  parameter int REG_W   = 8
) (
  input  logic [NUM_GRP-1:0]        grp_hit_i,
  input  logic [NUM_GRP*GRP_CH-1:0] flags_i,
  output logic [REG_W-1:0]          rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (grp_hit_i[g]) rdata_o = rdata_o | REG_W'(flags_i[g*GRP_CH +: GRP_CH]);
    end
  end
endmodule

// File: rtl/dmairq_status.sv
module dmairq_status
  import dmairq_pkg::*;
#(
  parameter int NUM_CH     = DEF_NUM_CH,
  parameter int GRP_CH     = DEF_GRP_CH,
  parameter int REG_W      = DEF_REG_W,
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int GRP_STRIDE = DEF_GRP_STRIDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_req_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic [NUM_CH-1:0] flag_o,
  output logic              pending_o
);
  localparam int NUM_GRP = grp_count(NUM_CH, GRP_CH);
  localparam int PAD_W   = NUM_GRP * GRP_CH;

  logic [NUM_GRP-1:0] grp_hit, grp_wr;
  logic [PAD_W-1:0]   req_pad, flags_all;
  logic               pending_q;

  assign req_pad = PAD_W'(ch_req_i);

  dmairq_decode #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W), .GRP_STRIDE(GRP_STRIDE)) u_decode (
    .bus_en_i  (bus_en_i),
    .bus_we_i  (bus_we_i),
    .bus_addr_i(bus_addr_i),
    .grp_hit_o (grp_hit),
    .grp_wr_o  (grp_wr)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
    dmairq_bank #(.GRP_CH(GRP_CH), .BASE_CH(g*GRP_CH), .NUM_CH(NUM_CH)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_pad[g*GRP_CH +: GRP_CH]),
      .wr_i   (grp_wr[g]),
      .wdata_i(bus_wdata_i[GRP_CH-1:0]),
      .flag_o (flags_all[g*GRP_CH +: GRP_CH])
    );
  end

  if (REG_W > GRP_CH) begin : g_unused_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata_i[REG_W-1:GRP_CH];
  end

  dmairq_readmux #(.NUM_GRP(NUM_GRP), .GRP_CH(GRP_CH), .REG_W(REG_W)) u_readmux (
    .grp_hit_i(grp_hit),
    .flags_i  (flags_all),
    .rdata_o  (bus_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= |flags_all;
  end

  assign pending_o = pending_q;
  assign flag_o    = flags_all[NUM_CH-1:0];

  assert_pending_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o == $past(|flag_o));
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_o[REG_W-1:GRP_CH] == '0);
  assert_other_addr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en_i || (int'(bus_addr_i) % GRP_STRIDE != 0)
     || (int'(bus_addr_i) / GRP_STRIDE >= NUM_GRP)) |-> bus_rdata_o == '0);
endmodule

// File: tb/sim_dmairq_status.sv
module sim_dmairq_status;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] ch_req;
  logic       bus_en, bus_we;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [9:0] flags;
  logic       pending;

  int checks = 0;
  int errors = 0;
  logic [9:0] model = '0;
  bit done = 0;

  always #10 clk = ~clk;

  dmairq_status u0 (
    .clk(clk), .rst_n(rst_n), .ch_req_i(ch_req), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .flag_o(flags), .pending_o(pending)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic en, input logic [3:0] a, input logic [9:0] f);
    if (!en)         return 8'h00;
    if (a == 4'h0)   return {3'b000, f[4:0]};
    if (a == 4'h8)   return {3'b000, f[9:5]};
    return 8'h00;
  endfunction

  function automatic logic [9:0] next_flags(input logic [9:0] f, input logic [9:0] req,
      input logic en, input logic we, input logic [3:0] a, input logic [7:0] wd);
    logic [9:0] clr = '0;
    if (en && we && a == 4'h0) clr[4:0] = ~wd[4:0];
    if (en && we && a == 4'h8) clr[9:5] = ~wd[4:0];
    return (f & ~clr) | req;
  endfunction

  task automatic step(input string tag, input logic [9:0] req, input logic en, input logic we,
                      input logic [3:0] a, input logic [7:0] wd);
    logic pend_exp;
    @(negedge clk);
    ch_req = req; bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd;
    #1;
    chk({tag, " R10 rdata"}, 32'(bus_rdata), 32'(exp_rd(en, a, model)));
    pend_exp = |model;
    model = next_flags(model, req, en, we, a, wd);
    @(posedge clk);
    #1;
    chk({tag, " flags"}, 32'(flags), 32'(model));
    chk({tag, " R9 pending"}, 32'(pending), 32'(pend_exp));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; ch_req = '1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset flags", 32'(flags), 0);
    chk("R1 reset pending", 32'(pending), 0);
    chk("R1 reset rdata", 32'(bus_rdata), 0);
    ch_req = '0;
    rst_n = 1'b1;
    // R1: first cycle after reset, idle
    step("R1 idle", '0, 0, 0, 4'h0, 8'h00);
    // R2: single channel set
    step("R2 set ch0", 10'h001, 0, 0, 4'h0, 8'h00);
    step("R2 hold", '0, 1, 0, 4'h0, 8'h00);
    // R2/R3: set all, read both registers
    step("R2 set all", 10'h3FF, 0, 0, 4'h0, 8'h00);
    step("R3 read low", '0, 1, 0, 4'h0, 8'h00);
    step("R3 read high", '0, 1, 0, 4'h8, 8'h00);
    // R5: writing ones preserves
    step("R5 write ones low", '0, 1, 1, 4'h0, 8'hFF);
    step("R5 write ones high", '0, 1, 1, 4'h8, 8'hFF);
    // R4: clear only ch0, then ch9
    step("R4 clear ch0", '0, 1, 1, 4'h0, 8'hFE);
    step("R4 clear ch9", '0, 1, 1, 4'h8, 8'hEF);
    // R8: writes elsewhere ignored, reads elsewhere zero
    step("R8 write addr4", '0, 1, 1, 4'h4, 8'h00);
    step("R8 write addr9", '0, 1, 1, 4'h9, 8'h00);
    step("R8 read addr1", '0, 1, 0, 4'h1, 8'h00);
    step("R8 read addrF", '0, 1, 0, 4'hF, 8'h00);
    // R6: clear all, then write ones: nothing sets
    step("R4 clear all low", '0, 1, 1, 4'h0, 8'h00);
    step("R4 clear all high", '0, 1, 1, 4'h8, 8'h00);
    step("R6 write ones low", '0, 1, 1, 4'h0, 8'hFF);
    step("R6 write ones high", '0, 1, 1, 4'h8, 8'hFF);
    step("R6 read low", '0, 1, 0, 4'h0, 8'h00);
    // R7: request and clear collide on ch7
    step("R7 set wins", 10'h080, 1, 1, 4'h8, 8'h00);
    step("R7 read high", '0, 1, 0, 4'h8, 8'h00);
    step("R7 set wins ch2", 10'h004, 1, 1, 4'h0, 8'h00);
    step("R4 clear rest", '0, 1, 1, 4'h0, 8'h00);
    step("R4 clear rest2", '0, 1, 1, 4'h8, 8'h00);
    step("R9 pending drops", '0, 0, 0, 4'h0, 8'h00);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] req = '0;
      logic [3:0] a;
      int sel;
      for (int c = 0; c < 10; c++) req[c] = ($urandom % 8) == 0;
      sel = $urandom % 8;
      a = (sel < 3) ? 4'h0 : (sel < 6) ? 4'h8 : 4'($urandom);
      step("random R2 R4 R5 R7 R8", req, 1'($urandom), 1'($urandom), a, 8'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule